// File: doc/BRIEF.md
# Compare Mask Lane Accumulator

This block collects the one-bit outcome that each lane of a 32-lane vector instruction produces, such as a compare result, a carry-out or an exec update, into a pending scalar mask. The mask goes to the scalar register file in a single write, and only after every lane has reported. A lane that executes late in the instruction therefore still reads the old register contents.

A start pulse opens an instruction. It carries a target kind and a destination register index. The kind picks the register the mask will land in: the named destination, the exec mask register for compare-and-update-exec operations, or the vector condition code register for carry-outs in the short two-source encoding. Lane results arrive one per cycle with a lane index. Only lanes that are active in the exec mask and report true set their bit. All other bits stay zero, whatever the register held before.

A commit pulse ends the instruction. One cycle later the accumulated mask appears on a scalar write port. A target equal to the null register index ends the instruction without a write. A second start before commit raises an error flag and is dropped.

Top module: `lane_mask_collector`

## Requirements
- R1: After synchronous active-low reset, `wr_en_o` and `err_o` are 0 and no instruction is open, so a commit on its own causes no write.
- R2: An accepted start opens an instruction with an all-zero pending mask. A lane result presented in the same cycle as the start is not counted.
- R3: While an instruction is open, a valid lane result sets bit `res_lane_i` of the pending mask only if `res_bit_i` is 1 and `exec_mask_i[res_lane_i]` is 1. False results and inactive lanes leave their bit 0. A result in the commit cycle is still counted.
- R4: A commit while an instruction is open drives `wr_en_o` high in the next cycle, with the resolved target on `wr_idx_o` and the mask on `wr_data_o`, and closes the instruction. A commit with no open instruction does nothing.
- R5: The register write port stays idle while an instruction is open. Nothing is written before commit.
- R6: Target kind 2'b01 (exec update) makes the target `EXEC_IDX` (default 126), whatever `dest_idx_i` holds.
- R7: Target kind 2'b10 (short carry) makes the target `VCC_IDX` (default 106). Kinds 2'b00 and 2'b11 use `dest_idx_i`.
- R8: If the resolved target equals `NULL_IDX` (default 124), the commit closes the instruction but `wr_en_o` stays 0.
- R9: A start while an instruction is open drives `err_o` high for one cycle in the next cycle. It is otherwise ignored: the open target and mask are unchanged.
- R10: `wr_en_o` is a single-cycle pulse, and `wr_data_o` carries the full LANES-bit mask (32 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Opens an instruction |
| kind_i | input | 2 | Target kind: 00/11 named, 01 exec, 10 short carry |
| dest_idx_i | input | 7 | Named destination register index |
| exec_mask_i | input | 32 | Active-lane mask |
| res_valid_i | input | 1 | A lane result is present |
| res_bit_i | input | 1 | Lane result value |
| res_lane_i | input | 5 | Lane of the result |
| commit_i | input | 1 | All lanes done; write the mask |
| wr_en_o | output | 1 | Scalar register write enable |
| wr_idx_o | output | 7 | Scalar register index written |
| wr_data_o | output | 32 | Mask written |
| err_o | output | 1 | Start arrived while an instruction was open |

## Verification
The bench feeds lanes in both forward and reverse order. It uses exec masks that switch off half the wave and result patterns where active lanes report false, so a design that kept stale bits or ignored exec would return extra ones. Every start cycle also carries a stray true result for lane 0. This exposes a design that accepts results before the instruction opens, and the instruction that follows a null-target commit exposes one that fails to clear the mask. The restart case checks that the error flag rises and that the first target still receives the write. Commits with nothing open, and any write during lane collection, appear as unexpected items at the scoreboard.

// File: rtl/lmc_pkg.sv
// Shared types of the lane mask collector.
// Assumes: the target kind code is part of the block's port contract.
package lmc_pkg;
    typedef enum logic [1:0] {
        TGT_NAMED  = 2'b00,
        TGT_EXEC   = 2'b01,
        TGT_CARRY  = 2'b10,
        TGT_NAMED2 = 2'b11
    } tgt_kind_e;
endpackage

// File: rtl/lmc_target_sel.sv
// Resolves the register that will receive the mask, from the target kind.
// Assumes: kind 2'b11 is treated as a named destination.
module lmc_target_sel
    import lmc_pkg::*;
#(
    parameter int IDX_W    = 7,
    parameter int VCC_IDX  = 106,
    parameter int EXEC_IDX = 126
) (
    input  logic [1:0]       kind_i,
    input  logic [IDX_W-1:0] dest_idx_i,
    output logic [IDX_W-1:0] tgt_o
);
    // pick the implicit register for exec-update and short-carry kinds
    always_comb begin
        unique case (tgt_kind_e'(kind_i))
            TGT_EXEC:  tgt_o = IDX_W'(EXEC_IDX);
            TGT_CARRY: tgt_o = IDX_W'(VCC_IDX);
            default:   tgt_o = dest_idx_i;
        endcase
    end
endmodule

// File: rtl/lmc_pending_mask.sv
// Holds the pending lane mask; one set term per lane, gated by exec.
// Assumes: clear_i and accept_i come from the commit controller.
module lmc_pending_mask #(
    parameter int LANES  = 32,
    parameter int LANE_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              clear_i,
    input  logic              res_valid_i,
    input  logic              res_bit_i,
    input  logic [LANE_W-1:0] res_lane_i,
    input  logic [LANES-1:0]  exec_mask_i,
    output logic [LANES-1:0]  pend_q_o,
    output logic [LANES-1:0]  pend_d_o
);
    logic [LANES-1:0] set_vec;

    // per-lane set condition: open, valid, true, addressed and active
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign set_vec[g] = accept_i && res_valid_i && res_bit_i &&
                            (res_lane_i == LANE_W'(g)) && exec_mask_i[g];
    end

    // merged view including this cycle's result
    assign pend_d_o = pend_q_o | set_vec;

    // mask register: cleared at open/commit, otherwise accumulates
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) pend_q_o <= '0;
        else                   pend_q_o <= pend_d_o;
    end
endmodule

// File: rtl/lmc_commit_ctrl.sv
// Tracks the open instruction, flags restarts and drives the write port.
// Assumes: at most one open instruction; commit wins over a same-cycle start.
module lmc_commit_ctrl #(
    parameter int LANES    = 32,
    parameter int IDX_W    = 7,
    parameter int NULL_IDX = 124
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             commit_i,
    input  logic [IDX_W-1:0] tgt_i,
    input  logic [LANES-1:0] pend_d_i,
    output logic             open_o,
    output logic             clear_o,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [LANES-1:0] wr_data_o,
    output logic             err_o
);
    logic [IDX_W-1:0] tgt_q;
    logic             do_commit;
    logic             do_open;

    assign do_commit = open_o && commit_i;
    assign do_open   = !open_o && start_i;
    assign clear_o   = do_commit || do_open;

    // instruction state, error flag and registered write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_o    <= 1'b0;
            tgt_q     <= '0;
            wr_en_o   <= 1'b0;
            wr_idx_o  <= '0;
            wr_data_o <= '0;
            err_o     <= 1'b0;
        end else begin
            err_o   <= start_i && open_o;
            wr_en_o <= 1'b0;
            if (do_commit) begin
                open_o    <= 1'b0;
                wr_en_o   <= (tgt_q != IDX_W'(NULL_IDX));
                wr_idx_o  <= tgt_q;
                wr_data_o <= pend_d_i;
            end else if (do_open) begin
                open_o <= 1'b1;
                tgt_q  <= tgt_i;
            end
        end
    end
endmodule

// File: rtl/lane_mask_collector.sv
// Top: gathers per-lane one-bit results into a mask, written once at commit.
// Assumes: one result per cycle; the caller commits after the last lane.
module lane_mask_collector #(
    parameter int LANES    = 32,
    parameter int IDX_W    = 7,
    parameter int NULL_IDX = 124,
    parameter int VCC_IDX  = 106,
    parameter int EXEC_IDX = 126,
    localparam int LANE_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        kind_i,
    input  logic [IDX_W-1:0]  dest_idx_i,
    input  logic [LANES-1:0]  exec_mask_i,
    input  logic              res_valid_i,
    input  logic              res_bit_i,
    input  logic [LANE_W-1:0] res_lane_i,
    input  logic              commit_i,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [LANES-1:0]  wr_data_o,
    output logic              err_o
);
    logic [IDX_W-1:0] tgt;
    logic             open_q;
    logic             clear;
    logic [LANES-1:0] pend_q;
    logic [LANES-1:0] pend_d;

    lmc_target_sel #(.IDX_W(IDX_W), .VCC_IDX(VCC_IDX), .EXEC_IDX(EXEC_IDX)) u_sel (
        .kind_i(kind_i), .dest_idx_i(dest_idx_i), .tgt_o(tgt)
    );

    lmc_pending_mask #(.LANES(LANES), .LANE_W(LANE_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .accept_i(open_q), .clear_i(clear),
        .res_valid_i(res_valid_i), .res_bit_i(res_bit_i), .res_lane_i(res_lane_i),
        .exec_mask_i(exec_mask_i), .pend_q_o(pend_q), .pend_d_o(pend_d)
    );

    lmc_commit_ctrl #(.LANES(LANES), .IDX_W(IDX_W), .NULL_IDX(NULL_IDX)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .commit_i(commit_i),
        .tgt_i(tgt), .pend_d_i(pend_d), .open_o(open_q), .clear_o(clear),
        .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o), .err_o(err_o)
    );
endmodule

// File: rtl/lmc_checker.sv
// Property checker for lane_mask_collector, attached by bind.
// Assumes: sees the top's ports plus its open flag and pending mask.
module lmc_checker #(
    parameter int LANES    = 32,
    parameter int IDX_W    = 7,
    parameter int NULL_IDX = 124
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             commit_i,
    input logic             wr_en_o,
    input logic [IDX_W-1:0] wr_idx_o,
    input logic             err_o,
    input logic             open_q,
    input logic [LANES-1:0] pend_q
);
    // R8
    null_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> wr_idx_o != IDX_W'(NULL_IDX));
    // R4
    write_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ($past(commit_i) && $past(open_q)));
    // R4
    clear_after_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (pend_q == '0 && !open_q));
    // R5
    no_early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |-> !wr_en_o);
    // R10
    one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);
    // R9
    restart_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && open_q) |=> err_o);
    // R9
    restart_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && open_q && !commit_i) |=> open_q);
endmodule

bind lane_mask_collector lmc_checker #(
    .LANES(LANES), .IDX_W(IDX_W), .NULL_IDX(NULL_IDX)
) chk_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .commit_i(commit_i),
    .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .err_o(err_o),
    .open_q(open_q), .pend_q(pend_q)
);

// File: tb/lane_mask_collector_tb.sv
module lane_mask_collector_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 32;
    localparam int IDX_W = 7;
    localparam int NULLR = 124;
    localparam int VCCR  = 106;
    localparam int EXECR = 126;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [1:0]       kind_i = '0;
    logic [IDX_W-1:0] dest_idx_i = '0;
    logic [LANES-1:0] exec_mask_i = '0;
    logic             res_valid_i = 1'b0;
    logic             res_bit_i = 1'b0;
    logic [4:0]       res_lane_i = '0;
    logic             commit_i = 1'b0;
    logic             wr_en_o;
    logic [IDX_W-1:0] wr_idx_o;
    logic [LANES-1:0] wr_data_o;
    logic             err_o;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;
    logic [IDX_W+LANES-1:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    lane_mask_collector dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .kind_i(kind_i),
        .dest_idx_i(dest_idx_i), .exec_mask_i(exec_mask_i),
        .res_valid_i(res_valid_i), .res_bit_i(res_bit_i), .res_lane_i(res_lane_i),
        .commit_i(commit_i), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o),
        .wr_data_o(wr_data_o), .err_o(err_o)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: every write must match the oldest expected item
    always @(negedge clk) begin
        if (rst_n && wr_en_o) begin
            if (exp_q.size() == 0)
                check(1'b0, "R5/R8 unexpected write", {25'd0, wr_idx_o, wr_data_o}, 64'd0);
            else begin
                logic [IDX_W+LANES-1:0] e;
                e = exp_q.pop_front();
                check({wr_idx_o, wr_data_o} == e, "R3/R4/R6/R7 write", {25'd0, wr_idx_o, wr_data_o}, {25'd0, e});
            end
        end
    end

    // driver: one instruction, stray lane-0 result on the start cycle
    task automatic run_instr(input logic [1:0] kind, input logic [IDX_W-1:0] idx,
                             input logic [IDX_W-1:0] exp_tgt, input logic [LANES-1:0] bits,
                             input logic [LANES-1:0] ex, input bit reverse);
        @(negedge clk);
        start_i = 1'b1; kind_i = kind; dest_idx_i = idx; exec_mask_i = ex;
        res_valid_i = 1'b1; res_bit_i = 1'b1; res_lane_i = 5'd0;   // R2 must be ignored
        for (int i = 0; i < LANES; i++) begin
            @(negedge clk);
            start_i = 1'b0;
            res_lane_i = reverse ? 5'(LANES-1-i) : 5'(i);
            res_bit_i  = bits[res_lane_i];
        end
        @(negedge clk);
        res_valid_i = 1'b0; commit_i = 1'b1;
        if (exp_tgt != IDX_W'(NULLR)) exp_q.push_back({exp_tgt, bits & ex});
        @(negedge clk);
        commit_i = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(wr_en_o == 1'b0, "R1 wr_en reset", 64'(wr_en_o), 64'd0);
        check(err_o == 1'b0, "R1 err reset", 64'(err_o), 64'd0);
        commit_i = 1'b1;                       // R1/R4 commit while idle
        @(negedge clk);
        commit_i = 1'b0;
        check(wr_en_o == 1'b0, "R4 idle commit", 64'(wr_en_o), 64'd0);
        @(negedge clk);

        run_instr(2'b00, 7'd10, 7'd10, 32'hA5A5_0F0F, 32'hFFFF_FFFF, 1'b0);  // R3 R7 named
        run_instr(2'b01, 7'd10, 7'(EXECR), 32'hFFFF_FFFF, 32'h0000_FFFF, 1'b1); // R6 R3 inactive
        run_instr(2'b10, 7'd3, 7'(VCCR), 32'h8000_0001, 32'hFFFF_FFFF, 1'b0);  // R7 carry
        run_instr(2'b00, 7'(NULLR), 7'(NULLR), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0); // R8
        run_instr(2'b00, 7'd20, 7'd20, 32'h0000_0000, 32'hFFFF_FFFF, 1'b1);  // R2 R3 false
        run_instr(2'b11, 7'd40, 7'd40, 32'h1234_5678, 32'hF0F0_F0F0, 1'b0);  // R7 kind 11

        // R9 restart while open
        @(negedge clk);
        start_i = 1'b1; kind_i = 2'b00; dest_idx_i = 7'd5; exec_mask_i = 32'hFFFF_FFFF;
        @(negedge clk);
        check(err_o == 1'b0, "R9 no flag on first start", 64'(err_o), 64'd0);
        kind_i = 2'b01; dest_idx_i = 7'd9;     // second start
        res_valid_i = 1'b1; res_bit_i = 1'b1; res_lane_i = 5'd7;
        @(negedge clk);
        start_i = 1'b0; res_valid_i = 1'b0;
        check(err_o == 1'b1, "R9 restart flag", 64'(err_o), 64'd1);
        @(negedge clk);
        check(err_o == 1'b0, "R9 flag one cycle", 64'(err_o), 64'd0);
        res_valid_i = 1'b1; res_bit_i = 1'b1; res_lane_i = 5'd31;
        @(negedge clk);
        res_valid_i = 1'b0; commit_i = 1'b1;
        exp_q.push_back({7'd5, 32'h8000_0080});
        @(negedge clk);
        commit_i = 1'b0;
        repeat (3) @(negedge clk);

        check(exp_q.size() == 0, "R4 all writes delivered", 64'(exp_q.size()), 64'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule